// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a single-cycle 32-bit processor and works out, every clock, where the next fetch comes from. It can choose from four sources:

- the sequential address, PC+4;
- a PC-relative branch target;
- a pseudo-direct jump target inside the current 256 MiB region;
- the full value of a register operand.

The decoder supplies one-hot-style control strobes for the conditional branches on equal and on not-equal, and for plain jump, jump-and-link and register jump. The register file supplies the two operands. Branch resolution compares the two operands for equality inside the block.

The choice is made by a small selector with four named sources:

| Source | When it is chosen | Address loaded |
|---|---|---|
| `SRC_SEQ` | default | PC+4 |
| `SRC_BRANCH` | a branch strobe is set and its condition holds | branch target |
| `SRC_JUMP` | plain jump or jump-and-link | pseudo-direct target |
| `SRC_REG` | register jump | operand A |

The transitions run from the strobes into one of these sources by fixed priority. The PC register then loads the address of the chosen source on the next rising clock edge, unless the stall input holds it. The block also presents PC+4 as the return address for a jump-and-link. It raises a flag when a register jump would load an address that is not word aligned.

Top module: `npc_unit`

## Requirements
- R1: An active-low reset `rst_n` (asynchronous) sets `pc_q` to 0x0040_0000.
- R2: With no control strobe and `stall` low, `pc_q` advances by 4 on each rising edge.
- R3: The branch target is PC+4 plus the 16-bit `imm_off` shifted left by two and sign-extended from bit 17, so 0xFFFF means -4 and 0x8000 means -131072.
- R4: `br_eq` is taken when `opnd_a == opnd_b`, and `br_ne` is taken when they differ. A taken branch loads the target on the next edge. An untaken one loads PC+4.
- R5: `jmp` and `jmp_link` load `{pc4[31:28], tgt_field, 2'b00}`, where pc4 is PC+4.
- R6: `jmp_reg` loads the full 32-bit `opnd_a` into the PC on the next edge, whatever its low bits are.
- R7: `link_val` always equals `pc_q + 4`. `link_we` is high exactly while `jmp_link` is high.
- R8: While `stall` is high, `pc_q` keeps its value whatever the other inputs are.
- R9: `misalign` is high exactly when `jmp_reg` is high and `opnd_a[1:0]` is not 00.
- R10: When several strobes are set at once, the priority is register jump, then jump or jump-and-link, then a taken branch, then the sequential address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Hold the PC this cycle |
| br_eq | input | 1 | Branch-if-equal strobe |
| br_ne | input | 1 | Branch-if-not-equal strobe |
| jmp | input | 1 | Pseudo-direct jump strobe |
| jmp_link | input | 1 | Pseudo-direct jump that also links |
| jmp_reg | input | 1 | Register jump strobe |
| imm_off | input | 16 | Branch word offset field |
| tgt_field | input | 26 | Jump target field |
| opnd_a | input | 32 | First register operand, also the register-jump address |
| opnd_b | input | 32 | Second register operand |
| pc_q | output | 32 | Current program counter |
| link_val | output | 32 | Return address, PC+4 |
| link_we | output | 1 | Return-address write strobe |
| misalign | output | 1 | Register-jump address not word aligned |

## Verification
The case hardest to reach from the ports is a pseudo-direct jump whose PC+4 has just crossed into a new 256 MiB region. Only then do bits 31:28 of the jump target differ from those of the current PC. The stimulus first uses a register jump to place the PC at 0x0FFF_FFFC, and then issues a jump, so the region bits come from 0x1000_0000. The other hard cases are deliberate strobe collisions, including all strobes set together, a jump combined with a taken branch, and a stall combined with a register jump. Most-negative branch offsets and misaligned register addresses are also covered. Each of these is compared against the bench's own model on every cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2,
        SRC_REG    = 2'd3
    } npc_src_e;

    typedef struct packed {
        logic is_beq;
        logic is_bne;
        logic is_j;
        logic is_jal;
        logic is_jr;
    } npc_ctl_t;

endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int TGT_W  = 26
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [IMM_W-1:0]  imm,
    input  logic [TGT_W-1:0]  tgt,
    output logic [ADDR_W-1:0] pc_plus4,
    output logic [ADDR_W-1:0] br_tgt,
    output logic [ADDR_W-1:0] jmp_tgt
);
    localparam int EXT_W = ADDR_W - IMM_W - 2;
    localparam int REG_W = ADDR_W - TGT_W - 2;

    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        pc_plus4 = pc + ADDR_W'(4);
        off_ext  = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        br_tgt   = pc_plus4 + off_ext;
        jmp_tgt  = {pc_plus4[ADDR_W-1 -: REG_W], tgt, 2'b00};
    end

endmodule

// File: rtl/npc_cond.sv
module npc_cond #(
    parameter int ADDR_W = 32
) (
    input  npc_pkg::npc_ctl_t ctl,
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    output logic              taken
);
    logic same;

    always_comb begin
        same  = (a == b);
        taken = (ctl.is_beq & same) | (ctl.is_bne & ~same);
    end

endmodule

// File: rtl/npc_select.sv
module npc_select #(
    parameter int ADDR_W = 32
) (
    input  npc_pkg::npc_ctl_t ctl,
    input  logic              taken,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic [ADDR_W-1:0] jmp_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    output npc_pkg::npc_src_e src,
    output logic [ADDR_W-1:0] next_pc
);
    import npc_pkg::*;

    always_comb begin
        if (ctl.is_jr)                    src = SRC_REG;
        else if (ctl.is_j || ctl.is_jal)  src = SRC_JUMP;
        else if (taken)                   src = SRC_BRANCH;
        else                              src = SRC_SEQ;
    end

    always_comb begin
        unique case (src)
            SRC_SEQ:    next_pc = seq_addr;
            SRC_BRANCH: next_pc = br_addr;
            SRC_JUMP:   next_pc = jmp_addr;
            SRC_REG:    next_pc = reg_addr;
            default:    next_pc = seq_addr;
        endcase
    end

    // R10: a branch is only chosen when its condition holds and no jump is asked
    always_comb begin
        if (src == SRC_BRANCH)
            p_branch_needs_taken_r10: assert (taken && !ctl.is_jr && !ctl.is_j && !ctl.is_jal);
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
    parameter int          ADDR_W   = 32,
    parameter int          IMM_W    = 16,
    parameter int          TGT_W    = 26,
    parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              br_eq,
    input  logic              br_ne,
    input  logic              jmp,
    input  logic              jmp_link,
    input  logic              jmp_reg,
    input  logic [IMM_W-1:0]  imm_off,
    input  logic [TGT_W-1:0]  tgt_field,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] link_val,
    output logic              link_we,
    output logic              misalign
);
    import npc_pkg::*;

    npc_ctl_t          ctl;
    npc_src_e          src;
    logic              taken;
    logic [ADDR_W-1:0] pc_plus4, br_tgt, jmp_tgt, next_pc;

    always_comb begin
        ctl.is_beq = br_eq;
        ctl.is_bne = br_ne;
        ctl.is_j   = jmp;
        ctl.is_jal = jmp_link;
        ctl.is_jr  = jmp_reg;
    end

    npc_targets #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_targets (
        .pc(pc_q), .imm(imm_off), .tgt(tgt_field),
        .pc_plus4(pc_plus4), .br_tgt(br_tgt), .jmp_tgt(jmp_tgt)
    );

    npc_cond #(.ADDR_W(ADDR_W)) u_cond (
        .ctl(ctl), .a(opnd_a), .b(opnd_b), .taken(taken)
    );

    npc_select #(.ADDR_W(ADDR_W)) u_select (
        .ctl(ctl), .taken(taken),
        .seq_addr(pc_plus4), .br_addr(br_tgt), .jmp_addr(jmp_tgt), .reg_addr(opnd_a),
        .src(src), .next_pc(next_pc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pc_q <= ADDR_W'(RESET_PC);
        else if (!stall) pc_q <= next_pc;
    end

    always_comb begin
        link_val = pc_plus4;
        link_we  = jmp_link;
        misalign = jmp_reg & (opnd_a[1:0] != 2'b00);
    end

    p_reset_value_r1: assert property (@(posedge clk)
        !rst_n |=> pc_q == ADDR_W'(RESET_PC));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !br_eq && !br_ne && !jmp && !jmp_link && !jmp_reg)
        |=> pc_q == $past(pc_q) + ADDR_W'(4));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc_q));

    p_reg_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && jmp_reg) |=> pc_q == $past(opnd_a));

    p_jump_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !jmp_reg && (jmp || jmp_link))
        |=> pc_q[TGT_W+1:0] == {$past(tgt_field), 2'b00});

endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        br_eq = 1'b0, br_ne = 1'b0, jmp = 1'b0, jmp_link = 1'b0, jmp_reg = 1'b0;
    logic [15:0] imm_off = '0;
    logic [25:0] tgt_field = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [31:0] pc_q, link_val;
    logic        link_we, misalign;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_pc;

    always #2 clk = ~clk;

    npc_unit i_npc_unit (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .br_eq(br_eq), .br_ne(br_ne), .jmp(jmp), .jmp_link(jmp_link), .jmp_reg(jmp_reg),
        .imm_off(imm_off), .tgt_field(tgt_field), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .pc_q(pc_q), .link_val(link_val), .link_we(link_we), .misalign(misalign)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, want);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] pc);
        logic [31:0] nxt;
        logic [31:0] seq = pc + 32'd4;
        logic        tk  = (br_eq && opnd_a == opnd_b) || (br_ne && opnd_a != opnd_b);
        if (stall)                 nxt = pc;
        else if (jmp_reg)          nxt = opnd_a;
        else if (jmp || jmp_link)  nxt = {seq[31:28], tgt_field, 2'b00};
        else if (tk)               nxt = seq + {{14{imm_off[15]}}, imm_off, 2'b00};
        else                       nxt = seq;
        return nxt;
    endfunction

    // drive one cycle of inputs, check combinational outputs, then the new PC
    task automatic step(input string tag, input logic s, input logic be, input logic bn,
                        input logic j, input logic jl, input logic jr,
                        input logic [15:0] im, input logic [25:0] tg,
                        input logic [31:0] a, input logic [31:0] b);
        stall = s; br_eq = be; br_ne = bn; jmp = j; jmp_link = jl; jmp_reg = jr;
        imm_off = im; tgt_field = tg; opnd_a = a; opnd_b = b;
        #1;
        chk({tag, " R7 link_val"}, link_val, exp_pc + 32'd4);
        chk({tag, " R7 link_we"}, {31'd0, link_we}, {31'd0, jl});
        chk({tag, " R9 misalign"}, {31'd0, misalign}, {31'd0, jr && (a[1:0] != 2'b00)});
        exp_pc = model(exp_pc);
        @(negedge clk);
        chk({tag, " pc"}, pc_q, exp_pc);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 16'h0, 26'h0, 32'h0, 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk("R1 reset pc", pc_q, 32'h0040_0000);
        rst_n = 1'b1;
        exp_pc = 32'h0040_0000;
        // R2 sequential
        idle("R2 seq a"); idle("R2 seq b"); idle("R2 seq c");
        // R3 R4 beq equal, positive offset
        step("R3 R4 beq taken", 0, 1, 0, 0, 0, 0, 16'h0010, 0, 32'h1234, 32'h1234);
        // R4 beq unequal falls through
        step("R4 beq not taken", 0, 1, 0, 0, 0, 0, 16'h0010, 0, 32'h1234, 32'h1235);
        // R3 R4 bne differ, offset -4 (0xFFFF)
        step("R3 R4 bne back", 0, 0, 1, 0, 0, 0, 16'hFFFF, 0, 32'h1, 32'h2);
        // R4 bne equal falls through
        step("R4 bne not taken", 0, 0, 1, 0, 0, 0, 16'hFFFF, 0, 32'h7, 32'h7);
        // R3 most negative offset
        step("R3 min offset", 0, 1, 0, 0, 0, 0, 16'h8000, 0, 32'h0, 32'h0);
        // R6 register jump aligned
        step("R6 jr aligned", 0, 0, 0, 0, 0, 1, 0, 0, 32'h0FFF_FFFC, 32'h0);
        // R5 jump across region boundary (pc4 = 0x1000_0000)
        step("R5 j region", 0, 0, 0, 1, 0, 0, 0, 26'h0000_123, 32'h0, 32'h0);
        // R5 R7 jal
        step("R5 R7 jal", 0, 0, 0, 0, 1, 0, 0, 26'h3FF_FFFF, 32'h0, 32'h0);
        idle("R2 seq after jal");
        // R8 stall with register jump and branch
        step("R8 stall jr", 1, 1, 0, 0, 0, 1, 16'h0004, 0, 32'h0000_0100, 32'h0000_0100);
        step("R8 stall j", 1, 0, 0, 1, 0, 0, 0, 26'h55, 32'h0, 32'h0);
        // R10 all strobes set
        step("R10 all", 0, 1, 1, 1, 1, 1, 16'h0040, 26'h77, 32'h0000_0800, 32'h0000_0800);
        // R10 jump beats taken branch
        step("R10 j over br", 0, 1, 0, 1, 0, 0, 16'h0040, 26'h99, 32'h5, 32'h5);
        // R10 jr beats jump
        step("R10 jr over j", 0, 0, 0, 1, 0, 1, 0, 26'h11, 32'h0000_2000, 32'h0);
        // R9 R6 misaligned register jump
        step("R9 R6 jr misaligned", 0, 0, 0, 0, 0, 1, 0, 0, 32'h0000_3002, 32'h0);
        idle("R2 seq misaligned");
        step("R9 R6 jr misaligned 1", 0, 0, 0, 0, 0, 1, 0, 0, 32'h0000_4001, 32'h0);
        step("R6 jr realign", 0, 0, 0, 0, 0, 1, 0, 0, 32'h0040_0100, 32'h0);
        idle("R2 seq end");
        // R1 reset mid-run
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", pc_q, 32'h0040_0000);
        @(negedge clk);
        rst_n = 1'b1;
        exp_pc = 32'h0040_0000;
        idle("R2 seq after reset");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule